// File: doc/BRIEF.md
# Oversampled Thermometer Requantizer

This block turns a slowly updated 9-bit feedback word into a fast stream of 4-bit codes for a unit-element current-steering DAC. It runs one modulator step for each cycle of a fast-step enable, and 100 steps make one base sample period. In each step it adds the word to a 5-bit residue left over from the previous step. The upper bits of that sum become the output code, and the lower bits become the new residue. The quantization error is therefore fed back with a first-order (1 − z⁻¹) shaping, and over a base period the mean of the codes follows the word divided by 32.

A word offered with the load strobe waits in a staging register. It becomes the active word only at the first step of the next base period, and it then stays fixed for the 100 steps of that period. The code drives 15 equal-weight lines in thermometer form. A sum that would need code 16 is clamped to code 15, with the residue held at its maximum.

Top module: `dsm_therm_enc`

## Requirements
- R1: A synchronous reset drives all 15 lines low at the first clock edge where reset is high. It also clears the residue to 0, empties the staging register to 0 and restarts the base period at step 0.
- R2: A word offered with `word_load` high is written into the staging register, whether `step_en` is high or low. If several words are loaded before the next boundary, the last one wins. A word loaded in the middle of a base period has no effect on any line until that period has ended.
- R3: Each enabled step forms the sum S = active word + residue. When S < 512, the code is S / 32 (integer division) and the new residue is S mod 32.
- R4: The line outputs show the code of the most recent step: line i (bit i of `dac_lines`) is high exactly when the code is greater than i, so the number of high lines equals the code.
- R5: With a constant word w ≤ 480 held over one base period, the code total T over its 100 steps satisfies |32·T − 100·w| < 32.
- R6: When S ≥ 512, the code saturates at 15 (all lines high) and does not wrap; the new residue is 31. A word of 511 keeps all lines high for every step of its period.
- R7: While `step_en` is low, the lines, the residue and the step position do not change.
- R8: The base period is exactly 100 enabled steps. The staged word becomes active at step 0 of each period, which is the first enabled step after reset or after 100 earlier steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One modulator step per cycle where high |
| word_load | input | 1 | Strobe that writes `word_in` into the staging register |
| word_in | input | 9 | Feedback word, unsigned |
| dac_lines | output | 15 | Thermometer enables for the unit elements |

## Verification
A wrong residue does not show up in the current code. It shows up in the code of the next enabled step, because the residue decides when the sum crosses a multiple of 32. The bench therefore compares every line against a behavioural model on every clock, so a residue fault is reported one step after it appears. A step counter that is off by one moves the step where a staged word takes effect, and that shows within one period as a mismatch at the boundary. The cases that are easy to get wrong are a clamped residue, a word loaded in the middle of a period, and a reset during stepping; each of these is placed at a point where the expected code changes.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int DSM_IN_W  = 9;
    localparam int DSM_OUT_W = 4;
    localparam int DSM_OSR   = 100;

    typedef enum logic {
        SLOT_LOAD = 1'b1,
        SLOT_HOLD = 1'b0
    } slot_e;

    function automatic int unsigned dsm_lines(input int unsigned out_w);
        return (1 << out_w) - 1;
    endfunction
endpackage

// File: rtl/dsm_step_ctr.sv
module dsm_step_ctr #(
    parameter int OSR = dsm_pkg::DSM_OSR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    output dsm_pkg::slot_e slot
);
    localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (step_en) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
        end
    end

    assign slot = (pos_q == '0) ? dsm_pkg::SLOT_LOAD : dsm_pkg::SLOT_HOLD;

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST); // R8
endmodule

// File: rtl/dsm_quant.sv
module dsm_quant #(
    parameter int IN_W  = dsm_pkg::DSM_IN_W,
    parameter int OUT_W = dsm_pkg::DSM_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  dsm_pkg::slot_e   slot,
    input  logic [IN_W-1:0]  staged,
    output logic [OUT_W-1:0] code
);
    localparam int ERR_W = IN_W - OUT_W;
    localparam int SUM_W = IN_W + 1;

    logic [IN_W-1:0]  held_q;
    logic [IN_W-1:0]  cur_w;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_d;
    logic [SUM_W-1:0] sum;
    logic [OUT_W:0]   raw;
    logic             sat;
    logic [OUT_W-1:0] code_d;
    logic [OUT_W-1:0] code_q;

    always_comb begin
        cur_w  = (slot == dsm_pkg::SLOT_LOAD) ? staged : held_q;
        sum    = {1'b0, cur_w} + SUM_W'(err_q);
        raw    = sum[SUM_W-1:ERR_W];
        sat    = raw[OUT_W];
        code_d = sat ? '1 : raw[OUT_W-1:0];
        err_d  = sat ? '1 : sum[ERR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            err_q  <= '0;
            code_q <= '0;
        end else if (step_en) begin
            held_q <= cur_w;
            err_q  <= err_d;
            code_q <= code_d;
        end
    end

    assign code = code_q;

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (step_en && sat) |=> (code_q == '1 && err_q == '1)); // R6
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (step_en && slot == dsm_pkg::SLOT_HOLD) |=> $stable(held_q)); // R2
endmodule

// File: rtl/dsm_therm.sv
module dsm_therm #(
    parameter int OUT_W = dsm_pkg::DSM_OUT_W,
    parameter int LINES = (1 << OUT_W) - 1
) (
    input  logic [OUT_W-1:0] code,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (code > OUT_W'(i));
    end
endmodule

// File: rtl/dsm_therm_enc.sv
module dsm_therm_enc #(
    parameter int IN_W  = dsm_pkg::DSM_IN_W,
    parameter int OUT_W = dsm_pkg::DSM_OUT_W,
    parameter int OSR   = dsm_pkg::DSM_OSR,
    parameter int LINES = (1 << OUT_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             word_load,
    input  logic [IN_W-1:0]  word_in,
    output logic [LINES-1:0] dac_lines
);
    logic [IN_W-1:0]  staged_q;
    dsm_pkg::slot_e   slot;
    logic [OUT_W-1:0] code;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
        end else if (word_load) begin
            staged_q <= word_in;
        end
    end

    dsm_step_ctr #(.OSR(OSR)) u_ctr (
        .clk(clk), .rst(rst), .step_en(step_en), .slot(slot)
    );

    dsm_quant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
        .clk(clk), .rst(rst), .step_en(step_en), .slot(slot),
        .staged(staged_q), .code(code)
    );

    dsm_therm #(.OUT_W(OUT_W), .LINES(LINES)) u_therm (
        .code(code), .lines(dac_lines)
    );

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (dac_lines & LINES'(dac_lines + LINES'(1))) == '0); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(dac_lines)); // R7
    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> dac_lines == '0); // R1
endmodule

// File: tb/dsm_therm_enc_bench.sv
module dsm_therm_enc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        word_load = 1'b0;
    logic [8:0]  word_in = '0;
    logic [14:0] dac_lines;

    int n_chk = 0;
    int n_fail = 0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    dsm_therm_enc u_dsm_therm_enc (
        .clk(clk), .rst(rst), .step_en(step_en), .word_load(word_load),
        .word_in(word_in), .dac_lines(dac_lines)
    );

    // Behavioural reference: integers only
    int m_staged, m_held, m_err, m_pos, m_code;

    always @(posedge clk) begin
        int cur, s, q, e;
        if (rst) begin
            m_staged <= 0; m_held <= 0; m_err <= 0; m_pos <= 0; m_code <= 0;
        end else begin
            if (word_load) m_staged <= int'(word_in);
            if (step_en) begin
                cur = (m_pos == 0) ? m_staged : m_held;
                s = cur + m_err;
                if (s >= 512) begin q = 15; e = 31; end
                else begin q = s / 32; e = s % 32; end
                m_held <= cur; m_err <= e; m_code <= q;
                m_pos <= (m_pos == 99) ? 0 : m_pos + 1;
            end
        end
        live <= 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 R4: per-clock comparison against the model
    always @(negedge clk) begin
        if (live) begin
            chk(dac_lines == 15'((1 << m_code) - 1), "R3/R4 lines vs model",
                int'(dac_lines), (1 << m_code) - 1);
            chk($countones(dac_lines) == m_code, "R4 count of high lines",
                $countones(dac_lines), m_code);
        end
    end

    task automatic run(input int n, output int tot);
        tot = 0;
        step_en = 1'b1;
        repeat (n) begin
            @(negedge clk);
            tot += $countones(dac_lines);
        end
        step_en = 1'b0;
    endtask

    task automatic load_idle(input int w);
        word_in = 9'(w); word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
    endtask

    task automatic check_mean(input int w, input int tot);
        int d;
        d = 32 * tot - 100 * w;
        chk(d > -32 && d < 32, "R5 period mean", 32 * tot, 100 * w);
    endtask

    task automatic run_expect(input int n, input int lines_exp, input string req);
        step_en = 1'b1;
        repeat (n) begin
            @(negedge clk);
            chk(int'(dac_lines) == lines_exp, req, int'(dac_lines), lines_exp);
        end
        step_en = 1'b0;
    endtask

    initial begin
        #500_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int tot;
        logic [14:0] snap;
        repeat (3) @(negedge clk);
        chk(dac_lines == '0, "R1 lines low in reset", int'(dac_lines), 0);
        rst = 1'b0;

        // Period 1: word 100
        load_idle(100);
        run(100, tot);
        check_mean(100, tot);

        // Period 2: word 100 still active; word 0 staged mid-period (R2)
        run(10, tot);
        step_en = 1'b1; word_in = 9'd0; word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
        run(89, tot);

        // Period 3: word 0 active; 511 staged mid-period, no effect (R2)
        run_expect(50, 0, "R2 zero word held");
        step_en = 1'b1; word_in = 9'd511; word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
        chk(dac_lines == '0, "R2 mid-period load ignored", int'(dac_lines), 0);
        run_expect(49, 0, "R2 rest of period");

        // Period 4: first step takes 511 (R8), saturated throughout (R6)
        run_expect(1, 32767, "R8 boundary takes staged word");
        run_expect(99, 32767, "R6 saturation");

        // Idle cycles with a load: lines stay (R7)
        snap = dac_lines;
        word_in = 9'd240; word_load = 1'b1;
        repeat (5) begin
            @(negedge clk);
            word_load = 1'b0;
            chk(dac_lines == snap, "R7 idle hold", int'(dac_lines), int'(snap));
        end

        // Period 5: word 240 after clamped residue 31
        run(100, tot);
        check_mean(240, tot);

        // Period 6: word 240 with gapped stepping
        for (int k = 0; k < 10; k++) begin
            run(10, tot);
            @(negedge clk);
        end

        // Reset mid-run
        load_idle(300);
        run(137, tot);
        rst = 1'b1;
        @(negedge clk);
        chk(dac_lines == '0, "R1 reset clears lines", int'(dac_lines), 0);
        rst = 1'b0;
        run_expect(1, 0, "R1 staging emptied by reset");
        run(99, tot);
        load_idle(300);
        run(100, tot);
        check_mean(300, tot);
        load_idle(481);
        run(200, tot);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule